// File: doc/BRIEF.md
# Dual-Address Serial Expander Slave Front End

This block is the two-wire serial slave engine of a 16-line port expander. One shared engine answers two 7-bit bus addresses: one reaches the eight input lines, the other reaches the eight output lines. The upper three bits of each address are fixed per group. The lower four bits come from a separate address-pin decoder. The block oversamples SCL and SDA with the system clock through synchronizers and a glitch filter. It detects START and STOP, shifts bytes in and out MSB first, and pulls SDA low to acknowledge. It also pulls SDA low to send read data.

A write to the input-group address loads the interrupt mask, and a write to the output-group address loads the output latch. Multibyte writes reload the target on every byte. A read of the input group alternates a snapshot of the input pins with the transition-flag byte supplied by a neighbouring transition/interrupt unit. A read of the output group returns the sensed levels of the output pins. Every byte is sampled fresh during the acknowledge slot that precedes it.

The block sends three strobes to the transition unit:
- a pulse when the input-group address is acknowledged;
- a pulse for each read byte it loads, with that byte's parity index;
- a pulse on each STOP.

A separate active-low interface reset aborts any transfer. It leaves the mask, the latch and the interrupt logic alone.

Top module: `exp_i2c_front`

## Requirements
- R1: The slave acknowledges (SDA held low during the ninth clock) only the addresses {3'b110, addr_lo} (input group) and {3'b101, addr_lo} (output group). Any other address gets no acknowledge, and the bytes that follow have no effect.
- R2: Each byte written to the input-group address loads `irq_mask` and is acknowledged. Its reset value is 8'hFF.
- R3: Each byte written to the output-group address loads `out_latch` and is acknowledged. Its reset value is LATCH_RST (default 8'h00). In a multibyte write the latch holds the last byte.
- R4: A read of the input group returns, MSB first, the pin sample on bytes 0, 2, 4… and `flags_i` on bytes 1, 3, 5…. Each byte load pulses `rd_byte_p` with `rd_byte_idx` equal to 0 for pin bytes and 1 for flag bytes.
- R5: Each read byte is sampled during the acknowledge slot that precedes it (the address acknowledge for byte 0). A pin change after that slot shows up only in the next sampled byte.
- R6: A read of the output group returns `out_sense` resampled before every byte, and `rd_byte_idx` stays 0.
- R7: When the master does not acknowledge a read byte, the slave releases SDA. It then leaves SDA released for all further clocks until STOP or START.
- R8: Each STOP gives a one-cycle `stop_p`. A repeated START gives no `stop_p` and restarts address matching.
- R9: `addr_ack_p` pulses once each time the input-group address is acknowledged, for read or write. It never pulses for the output group.
- R10: A pulse on SCL or SDA that lasts at most FILT_CYC-1 clocks (default 5, i.e. 50 ns at 100 MHz) is ignored.
- R11: While `bus_rst_n` is low, the slave releases SDA and returns to idle without a `stop_p`. `irq_mask` and `out_latch` keep their values, and clocks sent after the reset are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_rst_n | input | 1 | Active-low interface abort |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_lo | input | 4 | Low address bits from the address-pin decoder |
| pins_i | input | 8 | Input-group pin levels |
| flags_i | input | 8 | Transition flags from the transition unit |
| out_sense | input | 8 | Sensed levels of the output pins |
| irq_mask | output | 8 | Interrupt mask register |
| out_latch | output | 8 | Output latch driving the output pins |
| addr_ack_p | output | 1 | Input-group address acknowledged |
| rd_byte_p | output | 1 | A read byte was sampled and loaded |
| rd_byte_idx | output | 1 | 0 pin/sense byte, 1 flag byte |
| stop_p | output | 1 | STOP condition seen |

## Verification
Every bus line passes two synchronizer flops, a FILT_CYC-cycle filter and one edge register before the engine reacts. The engine's registers follow one clock later, so SDA, the strobes, the mask and the latch change about ten clocks after the SCL edge that causes the change. The bench master keeps SCL low or high for forty clocks. It moves SDA only twenty clocks into the low phase, samples the acknowledge and read bits twenty clocks into the high phase, and reads registers only after a byte's acknowledge slot has ended. Strobes are counted by a monitor on the falling clock edge. Each check therefore sees a settled value, well past its due cycle and well before the next bus event.

// File: rtl/exp_pkg.sv
package exp_pkg;

    localparam logic [2:0] TAG_IN  = 3'b110;
    localparam logic [2:0] TAG_OUT = 3'b101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } xp_state_e;

    typedef struct packed {
        xp_state_e   fsm;
        logic [7:0]  shreg;
        logic [3:0]  bitc;
        logic        grp_in;
        logic        rnw;
        logic        mack;
        logic        idx;
        logic        sda_oe;
        logic [7:0]  mask;
        logic [7:0]  latch;
        logic        aack_p;
        logic        rd_p;
        logic        stop_p;
    } xp_regs_t;

endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int FILT_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          lvl_d, lvl_q;

    always_comb begin
        cnt_d = '0;
        lvl_d = lvl_q;
        if (sync_q[1] != lvl_q) begin
            if (cnt_q == CW'(FILT_CYC - 1)) begin
                lvl_d = sync_q[1];
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            lvl_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            cnt_q  <= cnt_d;
            lvl_q  <= lvl_d;
        end
    end

    assign level = lvl_q;
endmodule

// File: rtl/bus_event.sv
module bus_event (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_f;
            sda_p_q <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_p_q;
    assign scl_fall = ~scl_f & scl_p_q;
    assign start_c  = scl_f & scl_p_q & sda_p_q & ~sda_f;
    assign stop_c   = scl_f & scl_p_q & ~sda_p_q & sda_f;
endmodule

// File: rtl/exp_i2c_front.sv
module exp_i2c_front
    import exp_pkg::*;
#(
    parameter int         FILT_CYC  = 6,
    parameter int         PORT_W    = 8,
    parameter logic [7:0] LATCH_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [3:0]        addr_lo,
    input  logic [PORT_W-1:0] pins_i,
    input  logic [PORT_W-1:0] flags_i,
    input  logic [PORT_W-1:0] out_sense,
    output logic [PORT_W-1:0] irq_mask,
    output logic [PORT_W-1:0] out_latch,
    output logic              addr_ack_p,
    output logic              rd_byte_p,
    output logic              rd_byte_idx,
    output logic              stop_p
);
    localparam int LAST_BIT = PORT_W - 1;

    logic [1:0] line_raw, line_flt;
    logic       scl_rise, scl_fall, start_c, stop_c;
    logic [1:0] brst_q;
    xp_regs_t   st_d, st_q;

    assign line_raw = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            line_filter #(.FILT_CYC(FILT_CYC)) u_flt (
                .clk   (clk),
                .rst_n (rst_n),
                .raw   (line_raw[g]),
                .level (line_flt[g])
            );
        end
    endgenerate

    bus_event u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (line_flt[1]),
        .sda_f    (line_flt[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) brst_q <= 2'b11;
        else        brst_q <= {brst_q[0], bus_rst_n};
    end

    // Pick the byte to send: pins or flags for the input group, sense otherwise.
    function automatic logic [7:0] pick_tx(input logic grp, input logic idx,
                                           input logic [7:0] p, input logic [7:0] f,
                                           input logic [7:0] s);
        if (!grp)    return s;
        else if (idx) return f;
        else          return p;
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.aack_p = 1'b0;
        st_d.rd_p   = 1'b0;
        st_d.stop_p = 1'b0;

        if (!brst_q[1]) begin
            st_d.fsm    = ST_IDLE;
            st_d.sda_oe = 1'b0;
            st_d.bitc   = '0;
        end else if (stop_c) begin
            st_d.fsm    = ST_IDLE;
            st_d.sda_oe = 1'b0;
            st_d.stop_p = 1'b1;
        end else if (start_c) begin
            st_d.fsm    = ST_ADDR;
            st_d.sda_oe = 1'b0;
            st_d.bitc   = '0;
        end else begin
            unique case (st_q.fsm)
                ST_IDLE, ST_SKIP: begin
                    st_d.sda_oe = 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        st_d.shreg = {st_q.shreg[6:0], line_flt[0]};
                        st_d.bitc  = st_q.bitc + 1'b1;
                    end else if (scl_fall && st_q.bitc == 4'd8) begin
                        st_d.rnw = st_q.shreg[0];
                        if (st_q.shreg[7:1] == {TAG_IN, addr_lo}) begin
                            st_d.fsm    = ST_AACK;
                            st_d.grp_in = 1'b1;
                            st_d.sda_oe = 1'b1;
                            st_d.aack_p = 1'b1;
                        end else if (st_q.shreg[7:1] == {TAG_OUT, addr_lo}) begin
                            st_d.fsm    = ST_AACK;
                            st_d.grp_in = 1'b0;
                            st_d.sda_oe = 1'b1;
                        end else begin
                            st_d.fsm = ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        st_d.bitc = '0;
                        if (st_q.rnw) begin
                            st_d.fsm    = ST_RDATA;
                            st_d.idx    = 1'b0;
                            st_d.shreg  = pick_tx(st_q.grp_in, 1'b0, pins_i, flags_i, out_sense);
                            st_d.sda_oe = ~st_d.shreg[7];
                            st_d.rd_p   = 1'b1;
                        end else begin
                            st_d.fsm    = ST_WDATA;
                            st_d.sda_oe = 1'b0;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        st_d.shreg = {st_q.shreg[6:0], line_flt[0]};
                        st_d.bitc  = st_q.bitc + 1'b1;
                    end else if (scl_fall && st_q.bitc == 4'd8) begin
                        if (st_q.grp_in) st_d.mask  = st_q.shreg;
                        else             st_d.latch = st_q.shreg;
                        st_d.fsm    = ST_WACK;
                        st_d.sda_oe = 1'b1;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        st_d.fsm    = ST_WDATA;
                        st_d.sda_oe = 1'b0;
                        st_d.bitc   = '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (st_q.bitc == 4'(LAST_BIT)) begin
                            st_d.fsm    = ST_RACK;
                            st_d.sda_oe = 1'b0;
                            st_d.mack   = 1'b0;
                            st_d.bitc   = '0;
                        end else begin
                            st_d.shreg  = {st_q.shreg[6:0], 1'b0};
                            st_d.sda_oe = ~st_q.shreg[6];
                            st_d.bitc   = st_q.bitc + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        st_d.mack = ~line_flt[0];
                    end else if (scl_fall) begin
                        if (st_q.mack) begin
                            st_d.fsm    = ST_RDATA;
                            st_d.idx    = st_q.grp_in & ~st_q.idx;
                            st_d.shreg  = pick_tx(st_q.grp_in, st_d.idx, pins_i, flags_i, out_sense);
                            st_d.sda_oe = ~st_d.shreg[7];
                            st_d.rd_p   = 1'b1;
                            st_d.bitc   = '0;
                        end else begin
                            st_d.fsm    = ST_SKIP;
                            st_d.sda_oe = 1'b0;
                        end
                    end
                end
                default: st_d.fsm = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.fsm    <= ST_IDLE;
            st_q.mask   <= 8'hFF;
            st_q.latch  <= LATCH_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe      = st_q.sda_oe;
    assign irq_mask    = st_q.mask;
    assign out_latch   = st_q.latch;
    assign addr_ack_p  = st_q.aack_p;
    assign rd_byte_p   = st_q.rd_p;
    assign rd_byte_idx = st_q.idx;
    assign stop_p      = st_q.stop_p;
endmodule

// File: rtl/exp_i2c_front_chk.sv
module exp_i2c_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rst_n,
    input logic       sda_oe,
    input logic [7:0] irq_mask,
    input logic [7:0] out_latch,
    input logic       addr_ack_p,
    input logic       rd_byte_p,
    input logic       stop_p
);
    // R8: a STOP leaves SDA released
    a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |-> !sda_oe);

    // R9: input-group address acknowledge drives SDA low
    a_r9_aack_drives: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_p |-> sda_oe);

    // R2: mask only changes as the slave opens a data acknowledge
    a_r2_mask_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_mask) |-> sda_oe);

    // R3: latch only changes as the slave opens a data acknowledge
    a_r3_latch_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_latch) |-> sda_oe);

    // R11: a held interface reset releases SDA
    a_r11_busrst_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rst_n && $past(!bus_rst_n) && $past(!bus_rst_n, 2) && $past(!bus_rst_n, 3))
        |-> !sda_oe);

    // R4: a byte load and a STOP never coincide
    a_r4_load_not_stop: assert property (@(posedge clk) disable iff (!rst_n)
        rd_byte_p |-> !stop_p);
endmodule

bind exp_i2c_front exp_i2c_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst_n  (bus_rst_n),
    .sda_oe     (sda_oe),
    .irq_mask   (irq_mask),
    .out_latch  (out_latch),
    .addr_ack_p (addr_ack_p),
    .rd_byte_p  (rd_byte_p),
    .stop_p     (stop_p)
);

// File: tb/exp_i2c_front_test.sv
module exp_i2c_front_test;
    localparam int Q = 20;
    localparam logic [3:0] ALO = 4'b1001;
    localparam logic [6:0] A_IN  = {3'b110, ALO};
    localparam logic [6:0] A_OUT = {3'b101, ALO};

    logic clk = 1'b0;
    logic rst_n = 1'b0, bus_rst_n = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] pins_i = 8'h00, flags_i = 8'h00, out_sense = 8'h00;
    logic sda_oe, addr_ack_p, rd_byte_p, rd_byte_idx, stop_p;
    logic [7:0] irq_mask, out_latch;
    logic sda_line;

    int checks = 0, fails = 0;
    int stop_cnt = 0, aack_cnt = 0, rd_cnt = 0;
    logic [7:0] idx_log = '0;
    bit done = 0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    exp_i2c_front uut (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_lo(ALO), .pins_i(pins_i), .flags_i(flags_i), .out_sense(out_sense),
        .irq_mask(irq_mask), .out_latch(out_latch),
        .addr_ack_p(addr_ack_p), .rd_byte_p(rd_byte_p),
        .rd_byte_idx(rd_byte_idx), .stop_p(stop_p)
    );

    always @(negedge clk) begin
        if (stop_p) stop_cnt++;
        if (addr_ack_p) aack_cnt++;
        if (rd_byte_p) begin
            rd_cnt++;
            idx_log = {idx_log[6:0], rd_byte_idx};
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one SCL period; optional sub-filter glitches on both lines while SCL is high
    task automatic clock_bit(input logic b, output logic got, input bit glitch = 0);
        sda_m = b; wt(Q);
        scl_m = 1'b1;
        if (glitch) begin
            wt(6); scl_m = 1'b0; wt(4); scl_m = 1'b1;
            wt(3); sda_m = ~b;  wt(4); sda_m = b;
            wt(3);
        end else wt(Q);
        got = sda_line; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked, input bit glitch = 0);
        logic g;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], g, glitch);
        clock_bit(1'b1, g);
        acked = ~g;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic g;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, g);
            v[i] = g;
        end
        clock_bit(~mack, g);
    endtask

    task automatic t_reset();
        chk("R2 reset mask", irq_mask, 8'hFF);
        chk("R3 reset latch", out_latch, 8'h00);
        chk("R7 reset sda", sda_oe, 0);
        chk("R8 reset stop", stop_p, 0);
    endtask

    task automatic t_write_out();
        logic a; int s0 = stop_cnt; int k0 = aack_cnt;
        bus_start();
        send_byte({A_OUT, 1'b0}, a); chk("R1 out addr ack", a, 1);
        send_byte(8'h3C, a); chk("R3 byte1 ack", a, 1);
        chk("R3 latch byte1", out_latch, 8'h3C);
        send_byte(8'hA5, a); chk("R3 latch byte2", out_latch, 8'hA5);
        bus_stop();
        chk("R8 stop pulse", stop_cnt - s0, 1);
        chk("R9 no aack for out group", aack_cnt - k0, 0);
    endtask

    task automatic t_write_mask();
        logic a; int k0 = aack_cnt;
        bus_start();
        send_byte({A_IN, 1'b0}, a); chk("R1 in addr ack", a, 1);
        send_byte(8'h5A, a); chk("R2 mask ack", a, 1);
        bus_stop();
        chk("R2 mask loaded", irq_mask, 8'h5A);
        chk("R9 aack on write", aack_cnt - k0, 1);
        chk("R3 latch untouched", out_latch, 8'hA5);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte({3'b110, 4'b1000, 1'b0}, a); chk("R1 foreign addr nack", a, 0);
        send_byte(8'h00, a); chk("R1 foreign data nack", a, 0);
        bus_stop();
        chk("R1 mask unchanged", irq_mask, 8'h5A);
        bus_start();
        send_byte({3'b100, ALO, 1'b0}, a); chk("R1 wrong tag nack", a, 0);
        bus_stop();
    endtask

    task automatic t_read_in();
        logic a; logic [7:0] v; int r0 = rd_cnt; int k0 = aack_cnt;
        pins_i = 8'h96; flags_i = 8'h0F;
        bus_start();
        send_byte({A_IN, 1'b1}, a); chk("R1 in read ack", a, 1);
        pins_i = 8'h21;
        recv_byte(v, 1'b1); chk("R5 byte0 sampled at addr ack", v, 8'h96);
        recv_byte(v, 1'b1); chk("R4 byte1 flags", v, 8'h0F);
        flags_i = 8'hC3;
        recv_byte(v, 1'b1); chk("R5 byte2 resampled pins", v, 8'h21);
        recv_byte(v, 1'b0); chk("R4 byte3 flags", v, 8'hC3);
        bus_stop();
        chk("R4 load count", rd_cnt - r0, 4);
        chk("R4 idx order", idx_log[3:0], 4'b0101);
        chk("R9 aack on read", aack_cnt - k0, 1);
    endtask

    task automatic t_read_out_nack();
        logic a, g; logic [7:0] v; int ones = 0;
        out_sense = 8'h77;
        bus_start();
        send_byte({A_OUT, 1'b1}, a); chk("R6 out read ack", a, 1);
        out_sense = 8'h88;
        recv_byte(v, 1'b1); chk("R6 byte0 sense", v, 8'h77);
        recv_byte(v, 1'b0); chk("R6 byte1 fresh", v, 8'h88);
        chk("R6 idx stays 0", idx_log[1:0], 2'b00);
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1, g);
            if (g) ones++;
        end
        chk("R7 sda released after nack", ones, 9);
        bus_stop();
    endtask

    task automatic t_rep_start();
        logic a; int s0 = stop_cnt;
        bus_start();
        send_byte({A_OUT, 1'b0}, a);
        send_byte(8'h11, a);
        bus_start();
        chk("R8 no stop on repeated start", stop_cnt - s0, 0);
        send_byte({A_IN, 1'b0}, a); chk("R8 readdressed ack", a, 1);
        send_byte(8'h33, a);
        bus_stop();
        chk("R8 latch before rs", out_latch, 8'h11);
        chk("R8 mask after rs", irq_mask, 8'h33);
        chk("R8 single stop", stop_cnt - s0, 1);
    endtask

    task automatic t_glitch();
        logic a;
        bus_start();
        send_byte({A_OUT, 1'b0}, a, 1'b1); chk("R10 addr ack with glitches", a, 1);
        send_byte(8'hA5, a, 1'b1); chk("R10 data ack with glitches", a, 1);
        bus_stop();
        chk("R10 latch intact", out_latch, 8'hA5);
    endtask

    task automatic t_bus_rst();
        logic a, g; int s0;
        bus_start();
        for (int i = 6; i >= 0; i--) clock_bit(A_OUT[i], g);
        clock_bit(1'b0, g);
        wt(Q / 2);
        chk("R11 ack driven before abort", sda_oe, 1);
        s0 = stop_cnt;
        bus_rst_n = 1'b0; wt(10); bus_rst_n = 1'b1; wt(4);
        chk("R11 sda released", sda_oe, 0);
        chk("R11 no stop pulse", stop_cnt - s0, 0);
        clock_bit(1'b1, g);
        send_byte(8'h00, a); chk("R11 no ack after abort", a, 0);
        bus_stop();
        chk("R11 latch kept", out_latch, 8'hA5);
        chk("R11 mask kept", irq_mask, 8'h33);
    endtask

    initial begin
        wt(5); rst_n = 1'b1; wt(5);
        t_reset();
        t_write_out();
        t_write_mask();
        t_wrong_addr();
        t_read_in();
        t_read_out_nack();
        t_rep_start();
        t_glitch();
        t_bus_rst();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule